// File: doc/BRIEF.md
# Paged Program Memory Address Expander

This block widens a 16-bit local processor address into an 18-bit global address so that a 64 KB local map can reach 256 KB of program storage. Local addresses from 0x8000 to 0xBFFF form a 16 KB window. Accesses there are sent to one of sixteen 16 KB pages, chosen by a 4-bit page register that software writes. The top quarter of the local map is always fixed to global page 0xF. The lower half maps to a fixed global region that is not flash.

A second 4-bit page register serves the debug port. It replaces the processor page register for window accesses only when the debug paging feature is enabled and the current access is a debug access.

While active debug mode is set and the processor page register holds 0xF, the last 256 bytes of the window (0xBF00 to 0xBFFF) are claimed by a debug firmware overlay. In that case the flash select is withheld and an overlay flag is raised instead.

The translation is purely combinational from the registered page values, so there is one result per cycle and no wait states.

Top module: `pgx_expander`

## Requirements
- R1: While reset is asserted, and after it is released, both page registers read 0x0 until they are written.
- R2: A local address with bits [15:14] = 2'b10 gives global address {page, local[13:0]} with flash_sel = 1. Here page is the processor page register unless R7 applies.
- R3: A local address with bits [15:14] = 2'b11 gives global address {4'hF, local[13:0]} with flash_sel = 1, whatever either page register holds.
- R4: A local address with bit 15 = 0 gives global address {2'b11, local[15:0]} with flash_sel = 0 and overlay_hit = 0.
- R5: A write with wr_sel = 0 stores wr_data in the processor page register on that clock edge. The new value shows on cpu_page_rd and in the translation from the next cycle, and the debug page register is unchanged.
- R6: A write with wr_sel = 1 stores wr_data in the debug page register on that clock edge. The new value shows on dbg_page_rd from the next cycle, and the processor page register is unchanged.
- R7: For a window access, the debug page register supplies the page bits when dbg_page_en = 1 and dbg_access = 1 are both set. If either one is 0, the processor page register is used.
- R8: overlay_hit is 1 exactly when dbg_active = 1, the processor page register equals 0xF, and the local address lies in 0xBF00 to 0xBFFF. flash_sel is 0 whenever overlay_hit is 1. The global address output keeps its paged value.
- R9: With wr_en = 0, neither page register changes, whatever wr_sel and wr_data hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_addr | input | 16 | Local address of the current access |
| wr_en | input | 1 | Page register write strobe |
| wr_sel | input | 1 | Write target: 0 processor page, 1 debug page |
| wr_data | input | 4 | Page value to write |
| dbg_active | input | 1 | Active debug mode |
| dbg_page_en | input | 1 | Debug paging feature enabled |
| dbg_access | input | 1 | Current access comes from the debug port or debug firmware |
| glb_addr | output | 18 | Expanded global address |
| flash_sel | output | 1 | Access targets program flash |
| overlay_hit | output | 1 | Access targets the debug firmware overlay |
| cpu_page_rd | output | 4 | Read-back of the processor page register |
| dbg_page_rd | output | 4 | Read-back of the debug page register |

## Verification
The assertions rely on two things about the inputs. The register write port carries known values whenever wr_en is high. The access qualifiers (dbg_active, dbg_page_en, dbg_access) are never unknown after reset. The bench meets both conditions because it drives every input from its own tasks with defined values on each cycle, including a stretch of random stimulus that draws only 0 or 1 for the qualifiers. That random stretch also sets the processor page to 0xF often, so the overlay condition is exercised alongside ordinary paging.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
    localparam int LOC_W  = 16;
    localparam int PAGE_W = 4;
    localparam int OFF_W  = LOC_W - 2;
    localparam int GLB_W  = PAGE_W + OFF_W;

    typedef struct packed {
        logic [PAGE_W-1:0] cpu;
        logic [PAGE_W-1:0] dbg;
    } page_state_t;
endpackage

// File: rtl/pgx_page_regs.sv
module pgx_page_regs
    import pgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [PAGE_W-1:0] wr_data,
    output logic [PAGE_W-1:0] cpu_page,
    output logic [PAGE_W-1:0] dbg_page
);
    page_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_sel) st_d.dbg = wr_data;
            else        st_d.cpu = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_page = st_q.cpu;
    assign dbg_page = st_q.dbg;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cpu_page == '0 && dbg_page == '0));
    assert_cpu_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (cpu_page == $past(wr_data) && $stable(dbg_page)));
    assert_dbg_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (dbg_page == $past(wr_data) && $stable(cpu_page)));
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(cpu_page) && $stable(dbg_page)));
endmodule

// File: rtl/pgx_translate.sv
module pgx_translate
    import pgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOC_W-1:0]  loc,
    input  logic [PAGE_W-1:0] cpu_page,
    input  logic [PAGE_W-1:0] dbg_page,
    input  logic              use_dbg,
    output logic [GLB_W-1:0]  glb,
    output logic              in_flash
);
    localparam int FILL_W = GLB_W - LOC_W;

    logic [1:0]        quad;
    logic [PAGE_W-1:0] sel_page;

    always_comb begin
        quad     = loc[LOC_W-1 -: 2];
        sel_page = use_dbg ? dbg_page : cpu_page;
        unique case (quad)
            2'b10: begin
                glb      = {sel_page, loc[OFF_W-1:0]};
                in_flash = 1'b1;
            end
            2'b11: begin
                glb      = {{PAGE_W{1'b1}}, loc[OFF_W-1:0]};
                in_flash = 1'b1;
            end
            default: begin
                glb      = {{FILL_W{1'b1}}, loc};
                in_flash = 1'b0;
            end
        endcase
    end

    assert_window_cpu_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (loc[LOC_W-1 -: 2] == 2'b10 && !use_dbg) |-> (glb[GLB_W-1 -: PAGE_W] == cpu_page && in_flash));
    assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (loc[LOC_W-1 -: 2] == 2'b11) |-> (&glb[GLB_W-1 -: PAGE_W] && in_flash));
endmodule

// File: rtl/pgx_overlay.sv
module pgx_overlay
    import pgx_pkg::*;
#(
    parameter logic [PAGE_W-1:0] OVL_PAGE    = '1,
    parameter int                OVL_SLICE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOC_W-1:0]  loc,
    input  logic [PAGE_W-1:0] cpu_page,
    input  logic              dbg_active,
    output logic              hit
);
    logic in_window;
    logic in_slice;

    always_comb begin
        in_window = (loc[LOC_W-1 -: 2] == 2'b10);
        in_slice  = &loc[OFF_W-1:OVL_SLICE_W];
        hit       = dbg_active && (cpu_page == OVL_PAGE) && in_window && in_slice;
    end

    assert_ovl_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (loc >= 16'hBF00 && loc <= 16'hBFFF && dbg_active));
endmodule

// File: rtl/pgx_expander.sv
module pgx_expander
    import pgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOC_W-1:0]  loc_addr,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [PAGE_W-1:0] wr_data,
    input  logic              dbg_active,
    input  logic              dbg_page_en,
    input  logic              dbg_access,
    output logic [GLB_W-1:0]  glb_addr,
    output logic              flash_sel,
    output logic              overlay_hit,
    output logic [PAGE_W-1:0] cpu_page_rd,
    output logic [PAGE_W-1:0] dbg_page_rd
);
    logic [PAGE_W-1:0] cpu_page, dbg_page;
    logic              use_dbg, in_flash, hit;

    assign use_dbg = dbg_page_en && dbg_access;

    pgx_page_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cpu_page(cpu_page), .dbg_page(dbg_page)
    );

    pgx_translate u_xlat (
        .clk(clk), .rst_n(rst_n), .loc(loc_addr), .cpu_page(cpu_page),
        .dbg_page(dbg_page), .use_dbg(use_dbg), .glb(glb_addr), .in_flash(in_flash)
    );

    pgx_overlay u_ovl (
        .clk(clk), .rst_n(rst_n), .loc(loc_addr), .cpu_page(cpu_page),
        .dbg_active(dbg_active), .hit(hit)
    );

    assign overlay_hit = hit;
    assign flash_sel   = in_flash && !hit;
    assign cpu_page_rd = cpu_page;
    assign dbg_page_rd = dbg_page;

    assert_low_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_addr[LOC_W-1] |-> (!flash_sel && !overlay_hit && &glb_addr[GLB_W-1 -: 2]));
    assert_dbg_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_page_en && dbg_access && loc_addr[LOC_W-1 -: 2] == 2'b10)
        |-> (glb_addr[GLB_W-1 -: PAGE_W] == dbg_page_rd));
    assert_ovl_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overlay_hit |-> (!flash_sel && cpu_page_rd == 4'hF));
endmodule

// File: tb/test_pgx_expander.sv
module test_pgx_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] loc_addr = '0;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [3:0]  wr_data = '0;
    logic        dbg_active = 1'b0, dbg_page_en = 1'b0, dbg_access = 1'b0;
    logic [17:0] glb_addr;
    logic        flash_sel, overlay_hit;
    logic [3:0]  cpu_page_rd, dbg_page_rd;

    int checks = 0;
    int errors = 0;
    int m_cpu = 0;
    int m_dbg = 0;

    always #2 clk = ~clk;

    pgx_expander i_pgx_expander (
        .clk(clk), .rst_n(rst_n), .loc_addr(loc_addr), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .dbg_active(dbg_active),
        .dbg_page_en(dbg_page_en), .dbg_access(dbg_access),
        .glb_addr(glb_addr), .flash_sel(flash_sel), .overlay_hit(overlay_hit),
        .cpu_page_rd(cpu_page_rd), .dbg_page_rd(dbg_page_rd)
    );

    task automatic compare(input string tag);
        int page, e_glb, e_fs, e_ovl;
        int a = int'(loc_addr);
        page = (dbg_page_en && dbg_access) ? m_dbg : m_cpu;
        if (a >= 32768 && a < 49152) begin
            e_glb = page * 16384 + (a % 16384); e_fs = 1;
        end else if (a >= 49152) begin
            e_glb = 15 * 16384 + (a % 16384); e_fs = 1;
        end else begin
            e_glb = 3 * 65536 + a; e_fs = 0;
        end
        e_ovl = (dbg_active && m_cpu == 15 && a >= 48896 && a <= 49151) ? 1 : 0;
        if (e_ovl == 1) e_fs = 0;
        checks++;
        if (int'(glb_addr) != e_glb || int'(flash_sel) != e_fs || int'(overlay_hit) != e_ovl
            || int'(cpu_page_rd) != m_cpu || int'(dbg_page_rd) != m_dbg) begin
            errors++;
            $display("FAIL %s: loc=%h got glb=%h fs=%0d ovl=%0d cpu=%0d dbg=%0d exp glb=%h fs=%0d ovl=%0d cpu=%0d dbg=%0d",
                tag, loc_addr, glb_addr, flash_sel, overlay_hit, cpu_page_rd, dbg_page_rd,
                e_glb, e_fs, e_ovl, m_cpu, m_dbg);
        end
    endtask

    task automatic step(input string tag, input logic [15:0] a, input logic we, input logic ws,
                        input logic [3:0] wd, input logic act, input logic pen, input logic acc);
        loc_addr = a; wr_en = we; wr_sel = ws; wr_data = wd;
        dbg_active = act; dbg_page_en = pen; dbg_access = acc;
        #1;
        compare(tag);
        @(posedge clk);
        if (we) begin
            if (ws) m_dbg = int'(wd);
            else    m_cpu = int'(wd);
        end
        @(negedge clk);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        loc_addr = 16'h8123; #1;
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        step("R1 after reset", 16'h8000, 0, 0, 0, 0, 0, 0);
        step("R2 page0 window", 16'hBFFF, 0, 0, 0, 0, 0, 0);
        step("R5 write cpu", 16'h9000, 1, 0, 4'h5, 0, 0, 0);
        step("R5 cpu visible", 16'hA5A5, 0, 0, 0, 0, 0, 0);
        step("R3 upper fixed", 16'hC000, 0, 0, 0, 0, 0, 0);
        step("R3 upper top", 16'hFFFF, 0, 0, 0, 1, 1, 1);
        step("R4 low region", 16'h0000, 0, 0, 0, 0, 0, 0);
        step("R4 low top", 16'h7FFF, 0, 0, 0, 1, 0, 0);
        step("R6 write dbg", 16'h8001, 1, 1, 4'h9, 0, 0, 0);
        step("R6 dbg visible", 16'h8001, 0, 0, 0, 0, 0, 0);
        step("R7 dbg selected", 16'h8777, 0, 0, 0, 0, 1, 1);
        step("R7 enable only", 16'h8777, 0, 0, 0, 0, 1, 0);
        step("R7 access only", 16'h8777, 0, 0, 0, 0, 0, 1);
        step("R9 no write", 16'h8000, 0, 1, 4'hE, 0, 0, 0);
        step("R9 no write sel0", 16'h8000, 0, 0, 4'h3, 0, 0, 0);
        step("R9 held", 16'h8000, 0, 0, 0, 0, 0, 0);
        step("R5 write cpu F", 16'hBF00, 1, 0, 4'hF, 1, 0, 0);
        step("R8 overlay low edge", 16'hBF00, 0, 0, 0, 1, 0, 0);
        step("R8 overlay high edge", 16'hBFFF, 0, 0, 0, 1, 1, 1);
        step("R8 below slice", 16'hBEFF, 0, 0, 0, 1, 0, 0);
        step("R8 debug inactive", 16'hBF80, 0, 0, 0, 0, 0, 0);
        step("R8 upper not overlay", 16'hFF00, 0, 0, 0, 1, 0, 0);
        step("R8 page not F", 16'hBF10, 1, 0, 4'hE, 1, 0, 0);
        step("R8 page E", 16'hBF10, 0, 0, 0, 1, 0, 0);
        for (int i = 0; i < 400; i++) begin
            logic [15:0] ra = 16'($urandom);
            logic [3:0]  rd = 4'($urandom);
            if (($urandom % 4) == 0) ra[15:8] = 8'hBF;
            if (($urandom % 3) == 0) rd = 4'hF;
            step("R2 random", ra, 1'($urandom % 3 == 0), 1'($urandom), rd,
                 1'($urandom), 1'($urandom), 1'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule